// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control unit and register-transfer datapath of a small accumulator machine. It runs each instruction as a series of subcycles: fetch, an optional indirect subcycle, execute, and then an optional interrupt subcycle. All traffic passes through one shared single-port memory port. Only the address register drives the address lines, and only the buffer register drives the write data lines. The program counter gives the fetch address. The instruction register keeps the opcode. The buffer register holds the word that moves to or from memory.

Each access is a request/valid handshake. The sequencer raises `mem_req` with address, write enable and write data. It holds all of them steady until the memory returns `mem_valid`, at least one cycle later. Interrupts are sampled only once an instruction has finished. When one is taken, the return address is written to a descending save area, the handler's start address goes into the program counter, and further interrupts are masked.

States and transitions:

- `FI_ADDR` copies PC into MAR and goes to `FI_MEM`.
- `FI_MEM` reads. On valid it loads MBR, increments PC and goes to `FI_IR`.
- `FI_IR` latches the opcode. It goes to `IND_ADDR` if the indirect bit is set, otherwise to `EX_ADDR`.
- `IND_ADDR` moves the MBR address field into MAR and goes to `IND_MEM`.
- `IND_MEM` reads the pointer into MBR on valid and goes to `EX_ADDR`.
- `EX_ADDR` loads MAR with the effective address. For a load or add it goes to `EX_RD`. For a store it copies the accumulator into MBR and goes to `EX_WR`. Branches, enable and no-ops finish here and go to `INT_CHK`.
- `EX_RD` and `EX_WR` go to `INT_CHK` on valid.
- `INT_CHK` goes to `INT_WR` when an interrupt is pending and enabled, otherwise to `FI_ADDR`.
- `INT_WR` goes to `FI_ADDR` on valid.

Top module: `rtcpu_seq`

## Requirements
- R1: While reset is active `mem_req` is low. After reset, the first access is a read of address 0.
- R2: Every instruction begins with a read at the current PC. The PC then advances by one.
- R3: When bit 11 of the instruction is set, one extra read at the address field is made before execute. The low 11 bits of the returned word become the effective address.
- R4: Load reads the effective address into the accumulator. Add reads it and adds it to the accumulator. Only add updates the zero flag (result is zero) and the carry flag (carry out of bit 15).
- R5: Store writes the accumulator to the effective address.
- R6: Jump always loads the PC with the effective address. Branch-if-zero does so when the zero flag is set, and branch-if-carry when the carry flag is set. None of them makes a memory access in execute.
- R7: Interrupt requests are ignored while the interrupt-enable flag is clear. The enable flag is set by the enable opcode.
- R8: A taken interrupt writes the address of the next instruction to the save pointer, which starts at 0x7FF and then decrements. It clears the enable flag and makes the next fetch at the vector address (default 0x080).
- R9: Once `mem_req` is raised, address, write enable and write data stay stable and the request stays up until `mem_valid`.
- R10: The instruction word carries the opcode in bits 15:12: 1 load, 2 store, 3 add, 4 branch-if-zero, 5 jump, 6 interrupt enable, 7 branch-if-carry. Any other opcode is a no-op. Bit 11 is the indirect flag and bits 10:0 are the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Level interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_valid |
| mem_valid | input | 1 | Access completion |

## Verification
The bench memory answers after zero, one or two extra wait cycles in rotation. A design that dropped its request early, or let the address drift while waiting, would issue stray accesses that the per-clock comparison catches. The program takes and skips both conditional branches after an add that wraps to zero. A swapped flag, or a flag updated by load, sends the next fetch to the wrong address. An indirect load and store, and a jump through the saved return address, check that the pointer and not the instruction field is used. The interrupt line is held high while interrupts are masked, so a design that ignored the enable flag would write a save word too early. Repeated interrupts show whether the save pointer decrements and whether the saved value is the next PC rather than the current one.

// File: rtl/rtcpu_pkg.sv
package rtcpu_pkg;

    localparam int OPW = 4;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_BRZ   = 4'd4,
        OP_JMP   = 4'd5,
        OP_EI    = 4'd6,
        OP_BRC   = 4'd7
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FI_ADDR,
        ST_FI_MEM,
        ST_FI_IR,
        ST_IND_ADDR,
        ST_IND_MEM,
        ST_EX_ADDR,
        ST_EX_RD,
        ST_EX_WR,
        ST_INT_CHK,
        ST_INT_WR
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic add;
        logic brz;
        logic brc;
        logic jmp;
        logic ei;
    } dec_t;

endpackage

// File: rtl/rtcpu_alu.sv
module rtcpu_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic          zero
);
    logic [DW:0] full;

    always_comb begin
        full  = {1'b0, opa} + {1'b0, opb};
        sum   = full[DW-1:0];
        carry = full[DW];
        zero  = (full[DW-1:0] == '0);
    end
endmodule

// File: rtl/rtcpu_decode.sv
module rtcpu_decode
    import rtcpu_pkg::*;
(
    input  logic [OPW-1:0] op_bits,
    output dec_t           dec
);
    always_comb begin
        dec = '0;
        unique case (op_bits)
            OP_LOAD:  dec.rd  = 1'b1;
            OP_ADD: begin
                dec.rd  = 1'b1;
                dec.add = 1'b1;
            end
            OP_STORE: dec.wr  = 1'b1;
            OP_BRZ:   dec.brz = 1'b1;
            OP_BRC:   dec.brc = 1'b1;
            OP_JMP:   dec.jmp = 1'b1;
            OP_EI:    dec.ei  = 1'b1;
            default:  dec = '0;
        endcase
    end
endmodule

// File: rtl/rtcpu_seq.sv
module rtcpu_seq
    import rtcpu_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          AW       = 11,
    parameter int unsigned VEC_ADDR = 'h080,
    parameter int unsigned SP_INIT  = 'h7FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_valid
);
    localparam logic [AW-1:0] VEC_A  = AW'(VEC_ADDR);
    localparam logic [AW-1:0] SP_A   = AW'(SP_INIT);
    localparam logic [AW-1:0] ONE_A  = AW'(1);
    localparam int            PADW   = DW - AW;

    seq_state_e     state_q, state_d;
    logic [AW-1:0]  pc_q, mar_q, sp_q;
    logic [DW-1:0]  mbr_q, acc_q;
    logic [OPW-1:0] ir_q;
    logic           zf_q, cf_q, ien_q;

    dec_t           dec;
    logic [DW-1:0]  alu_sum;
    logic           alu_carry, alu_zero;
    logic [AW-1:0]  ea;
    logic           take_br;

    rtcpu_decode u_dec (
        .op_bits (ir_q),
        .dec     (dec)
    );

    rtcpu_alu #(.DW(DW)) u_alu (
        .opa   (acc_q),
        .opb   (mem_rdata),
        .sum   (alu_sum),
        .carry (alu_carry),
        .zero  (alu_zero)
    );

    assign ea      = mbr_q[AW-1:0];
    assign take_br = dec.jmp || (dec.brz && zf_q) || (dec.brc && cf_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FI_ADDR;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FI_ADDR:  state_d = ST_FI_MEM;
            ST_FI_MEM:   if (mem_valid) state_d = ST_FI_IR;
            ST_FI_IR:    state_d = mbr_q[AW] ? ST_IND_ADDR : ST_EX_ADDR;
            ST_IND_ADDR: state_d = ST_IND_MEM;
            ST_IND_MEM:  if (mem_valid) state_d = ST_EX_ADDR;
            ST_EX_ADDR: begin
                if (dec.rd)      state_d = ST_EX_RD;
                else if (dec.wr) state_d = ST_EX_WR;
                else             state_d = ST_INT_CHK;
            end
            ST_EX_RD:    if (mem_valid) state_d = ST_INT_CHK;
            ST_EX_WR:    if (mem_valid) state_d = ST_INT_CHK;
            ST_INT_CHK:  state_d = (ien_q && irq) ? ST_INT_WR : ST_FI_ADDR;
            ST_INT_WR:   if (mem_valid) state_d = ST_FI_ADDR;
            default:     state_d = ST_FI_ADDR;
        endcase
    end

    // memory port outputs
    always_comb begin
        mem_req   = (state_q == ST_FI_MEM) || (state_q == ST_IND_MEM) ||
                    (state_q == ST_EX_RD)  || (state_q == ST_EX_WR)   ||
                    (state_q == ST_INT_WR);
        mem_we    = (state_q == ST_EX_WR) || (state_q == ST_INT_WR);
        mem_addr  = mar_q;
        mem_wdata = mbr_q;
    end

    // register transfers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mbr_q <= '0;
            acc_q <= '0;
            ir_q  <= '0;
            sp_q  <= SP_A;
            zf_q  <= 1'b0;
            cf_q  <= 1'b0;
            ien_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FI_ADDR: mar_q <= pc_q;
                ST_FI_MEM: if (mem_valid) begin
                    mbr_q <= mem_rdata;
                    pc_q  <= pc_q + ONE_A;
                end
                ST_FI_IR:    ir_q  <= mbr_q[DW-1 -: OPW];
                ST_IND_ADDR: mar_q <= ea;
                ST_IND_MEM:  if (mem_valid) mbr_q <= mem_rdata;
                ST_EX_ADDR: begin
                    mar_q <= ea;
                    if (dec.wr) mbr_q <= acc_q;
                    if (take_br) pc_q <= ea;
                    if (dec.ei) ien_q <= 1'b1;
                end
                ST_EX_RD: if (mem_valid) begin
                    if (dec.add) begin
                        acc_q <= alu_sum;
                        zf_q  <= alu_zero;
                        cf_q  <= alu_carry;
                    end else begin
                        acc_q <= mem_rdata;
                    end
                end
                ST_EX_WR: ;
                ST_INT_CHK: begin
                    mbr_q <= {{PADW{1'b0}}, pc_q};
                    mar_q <= sp_q;
                end
                ST_INT_WR: if (mem_valid) begin
                    sp_q  <= sp_q - ONE_A;
                    pc_q  <= VEC_A;
                    ien_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_FI_MEM && mem_valid) |=> (pc_q == $past(pc_q) + ONE_A)); // R2
    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_EX_ADDR && dec.jmp) |=> (pc_q == $past(mbr_q[AW-1:0]) && !mem_req)); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_INT_CHK && !ien_q) |=> (state_q == ST_FI_ADDR)); // R7
    AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_INT_WR && mem_valid) |=> (pc_q == VEC_A && !ien_q && state_q == ST_FI_ADDR)); // R8
    AST_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_INT_WR && mem_valid) |=> (sp_q == $past(sp_q) - ONE_A)); // R8
endmodule

// File: tb/tb_rtcpu_seq.sv
`timescale 1ns/1ps
module tb_rtcpu_seq;
    localparam int MAXT   = 400;
    localparam int LIMIT  = 20000;
    localparam logic [10:0] DOOR = 11'h7F0;
    localparam logic [10:0] VEC  = 11'h080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq;
    logic        mem_req, mem_we, mem_valid;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    rtcpu_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_valid (mem_valid)
    );

    logic [15:0] mem [0:2047];
    logic [15:0] ref_mem [0:2047];

    logic [10:0] exp_addr [0:MAXT-1];
    logic        exp_we   [0:MAXT-1];
    logic [15:0] exp_wd   [0:MAXT-1];
    string       exp_tag  [0:MAXT-1];
    int          nexp;

    int errors = 0;
    int checks = 0;
    int tidx   = 0;
    int cyc    = 0;

    function automatic logic [15:0] ins(input int op, input int ind, input int a);
        return {op[3:0], ind[0], a[10:0]};
    endfunction

    task automatic push(input logic [10:0] a, input logic w, input logic [15:0] d, input string t);
        if (nexp < MAXT) begin
            exp_addr[nexp] = a;
            exp_we[nexp]   = w;
            exp_wd[nexp]   = d;
            exp_tag[nexp]  = t;
            nexp++;
        end
    endtask

    task automatic load_program();
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
        // main program (R10 encoding)
        mem[0]  = ins(1, 0, 'h100);  // load 0xFFFF
        mem[1]  = ins(3, 0, 'h101);  // add 1 -> zero, carry
        mem[2]  = ins(7, 0, 4);      // brc taken
        mem[3]  = ins(2, 0, 'h200);
        mem[4]  = ins(4, 0, 6);      // brz taken
        mem[5]  = ins(2, 0, 'h201);
        mem[6]  = ins(2, 0, 'h202);  // store 0
        mem[7]  = ins(1, 1, 'h102);  // load indirect
        mem[8]  = ins(3, 0, 'h104);  // add, flags clear
        mem[9]  = ins(4, 0, 0);      // brz not taken
        mem[10] = ins(7, 0, 0);      // brc not taken
        mem[11] = ins(2, 1, 'h105);  // store indirect
        mem[12] = ins(6, 0, 0);      // enable interrupts
        mem[13] = ins(2, 0, DOOR);   // raise irq again
        mem[14] = ins(9, 0, 0);      // unused opcode: no-op
        mem[15] = ins(6, 0, 0);
        mem[16] = ins(5, 0, 13);
        mem['h100] = 16'hFFFF;
        mem['h101] = 16'h0001;
        mem['h102] = 16'h0103;
        mem['h103] = 16'h1234;
        mem['h104] = 16'h0001;
        mem['h105] = 16'hF203;       // upper bits ignored for address
        mem['h106] = 16'h00AA;
        // handler
        mem['h080] = ins(1, 0, 'h106);
        mem['h081] = ins(3, 0, 'h106);
        mem['h082] = ins(2, 0, 'h204);
        mem['h083] = ins(5, 1, 'h7FF);  // return through first saved word
        for (int i = 0; i < 2048; i++) ref_mem[i] = mem[i];
    endtask

    // behavioural instruction-level reference producing the expected bus transactions
    task automatic build_expect();
        logic [10:0] pc, ea, sp;
        logic [15:0] acc, w;
        logic [16:0] s;
        logic z, c, ien, irq_m;
        int op;
        string nt;
        pc = 0; acc = 0; z = 0; c = 0; ien = 0; irq_m = 1; sp = 11'h7FF; nt = "R1";
        nexp = 0;
        while (nexp < MAXT) begin
            push(pc, 1'b0, 16'h0, nt);
            w  = ref_mem[pc];
            pc = pc + 11'd1;
            nt = "R2";
            ea = w[10:0];
            op = int'(w[15:12]);
            if (w[11]) begin
                push(ea, 1'b0, 16'h0, "R3");
                ea = ref_mem[ea][10:0];
            end
            case (op)
                1: begin push(ea, 1'b0, 16'h0, "R10"); acc = ref_mem[ea]; end
                3: begin
                    push(ea, 1'b0, 16'h0, "R4");
                    s = {1'b0, acc} + {1'b0, ref_mem[ea]};
                    acc = s[15:0]; c = s[16]; z = (s[15:0] == 16'h0);
                end
                2: begin
                    push(ea, 1'b1, acc, "R5");
                    ref_mem[ea] = acc;
                    if (ea == DOOR) irq_m = 1;
                    else if (ea >= 11'h700) irq_m = 0;
                end
                4: if (z) begin pc = ea; nt = "R6"; end
                7: if (c) begin pc = ea; nt = "R6"; end
                5: begin pc = ea; nt = "R6"; end
                6: ien = 1;
                default: ;
            endcase
            if (ien && irq_m) begin
                push(sp, 1'b1, {5'b0, pc}, "R8");
                ref_mem[sp] = {5'b0, pc};
                sp = sp - 11'd1;
                pc = VEC; ien = 0; irq_m = 0; nt = "R8";
            end else if (irq_m) begin
                nt = "R7";
            end
        end
    endtask

    // memory responder with rotating latency
    int wcnt, lat;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_rdata <= 16'h0;
            irq       <= 1'b1;
            wcnt      <= 0;
            lat       <= 0;
        end else if (mem_req && !mem_valid) begin
            if (wcnt >= lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem[mem_addr];
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    if (mem_addr == DOOR) irq <= 1'b1;
                    else if (mem_addr >= 11'h700) irq <= 1'b0;
                end
                wcnt <= 0;
                lat  <= (lat + 1) % 3;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_valid <= 1'b0;
        end
    end

    // per-clock comparison against the reference
    logic        prev_wait;
    logic [10:0] prev_addr;
    logic        prev_we;
    logic [15:0] prev_wd;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (prev_wait) begin
                checks++;
                if (!(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd)) begin
                    errors++;
                    $display("FAIL R9 held request: actual req=%0b addr=%h we=%0b wd=%h expected req=1 addr=%h we=%0b wd=%h",
                             mem_req, mem_addr, mem_we, mem_wdata, prev_addr, prev_we, prev_wd);
                end
            end
            if (mem_req && mem_valid && tidx < MAXT) begin
                checks++;
                if (mem_addr != exp_addr[tidx] || mem_we != exp_we[tidx] ||
                    (exp_we[tidx] && mem_wdata != exp_wd[tidx])) begin
                    errors++;
                    $display("FAIL %s access %0d: actual addr=%h we=%0b wd=%h expected addr=%h we=%0b wd=%h",
                             exp_tag[tidx], tidx, mem_addr, mem_we, mem_wdata,
                             exp_addr[tidx], exp_we[tidx], exp_wd[tidx]);
                end
                tidx++;
            end
            prev_wait = mem_req && !mem_valid;
            prev_addr = mem_addr;
            prev_we   = mem_we;
            prev_wd   = mem_wdata;
        end else begin
            prev_wait = 1'b0;
        end
    end

    initial begin
        prev_wait = 1'b0;
        load_program();
        build_expect();
        repeat (3) @(negedge clk);
        checks++;  // R1 reset state
        if (mem_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual mem_req=%b expected 0", mem_req);
        end
        rst_n = 1'b1;
        while (tidx < MAXT && cyc < LIMIT) @(negedge clk);
        if (tidx < MAXT) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual accesses=%0d expected %0d", tidx, MAXT);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule